// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines from peripherals and presents them to a processor as a single interrupt output. Each line is captured into a request register, either on a rising edge or while the line is high, depending on the configuration. A per-input mask removes lines from arbitration. A resolver then forwards the best remaining request only when it outranks everything already in service.

The processor answers with two acknowledge strobes. On the first strobe the winning request moves from the request register into the in-service register. On the second strobe the block drives an 8-bit vector. The upper bits of the vector come from software and the low three bits are the index of the winner.

An in-service bit stays set until one of two things happens. In automatic mode it clears at the second strobe. Otherwise it clears when an end-of-interrupt command is written. Priority is either fixed, with input 0 highest, or rotating, where the input just serviced drops to the bottom of the order.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output and the vector-enable output are low. All mask bits are clear. The block is in edge mode, fixed priority and commanded end-of-interrupt, and the vector base is 0.
- R2: A configuration write takes effect only when `cs` and `wr_en` are both high at a clock edge. The address selects the target:
    - Address 0 is the setup word: bits [7:3] are the vector base, bit 2 selects rotating priority, bit 1 selects automatic end-of-interrupt and bit 0 selects level mode. A setup write also clears the in-service register and restores the default priority order.
    - Address 1 writes the mask.
    - Address 2 is a command; bit 5 set means a non-specific end-of-interrupt.
- R3: In fixed priority mode, input 0 has the highest priority and input 7 the lowest.
- R4: A mask bit set to 1 keeps that input out of arbitration, but a request that arrives while masked stays recorded. The request is forwarded once the mask bit is cleared.
- R5: `int_out` is high exactly when some unmasked pending request has strictly higher priority than every in-service bit.
- R6: In edge mode, a request is recorded on a low-to-high transition of the line. Dropping the line before the first acknowledge withdraws the request. A line that stays high after being serviced raises no new request.
- R7: In level mode, a high line requests service on every cycle, including again after its end-of-interrupt.
- R8: The first acknowledge strobe sets the winner's in-service bit and clears its request bit, and `vec_oe` stays low during that strobe.
- R9: During the second acknowledge strobe, `vec_oe` is high and `vec_out` equals the base in bits [7:3] joined with the winner's index in bits [2:0].
- R10: With automatic end-of-interrupt selected, the winner's in-service bit clears at the second strobe.
- R11: A non-specific end-of-interrupt command clears the highest-priority set in-service bit.
- R12: In rotating mode, the input whose in-service bit is cleared becomes the lowest priority, and the input after it becomes the highest.
- R13: The acknowledge strobes work whatever the level of `cs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines |
| cs | input | 1 | Select for configuration writes |
| wr_en | input | 1 | Configuration write strobe |
| addr | input | 2 | Configuration register select |
| wdata | input | 8 | Configuration write data |
| ack | input | 1 | Acknowledge strobe, one cycle per pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Interrupt vector, valid while vec_oe is high |
| vec_oe | output | 1 | Vector drive enable (second acknowledge strobe) |

## Verification
The assertions check several properties on every cycle:
- The vector is never driven on two strobes in a row.
- A forwarded first strobe adds exactly one in-service bit.
- Automatic end-of-interrupt removes exactly the bit of the vector just given.
- The interrupt output only rises with an unmasked request behind it.

Some behaviours depend on a history of stimulus, so only the directed scenarios can show them:
- The order chosen among simultaneous requests in fixed and rotating mode.
- Nesting of a higher request over one in service.
- The difference between edge and level re-requests.
- That writes without select are ignored.

// File: rtl/irq_pkg.sv
// Package: shared register addresses and setup-word bit positions for the
// priority interrupt controller. Assumes an 8-bit write data path.
package irq_pkg;
    localparam logic [1:0] ADDR_SETUP = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;
    localparam logic [1:0] ADDR_CMD   = 2'd2;
    localparam int BIT_LEVEL = 0;
    localparam int BIT_AUTO  = 1;
    localparam int BIT_ROT   = 2;
    localparam int BIT_EOI   = 5;
endpackage

// File: rtl/irq_req_capture.sv
// Request capture: one request bit per input line. In level mode the bit
// follows the line. In edge mode it sets on a rising edge and drops when the
// line falls. A clear pulse from the acknowledge logic wins over both.
// Assumes irq lines are already synchronous to clk.
module irq_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq,
    input  logic         level_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req
);
    logic [N-1:0] prev_q;

    // Remember last cycle's line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Update one request bit according to trigger mode.
        always_ff @(posedge clk) begin
            if (!rst_n)              req[i] <= 1'b0;
            else if (clr[i])         req[i] <= 1'b0;
            else if (level_mode)     req[i] <= irq[i];
            else if (!irq[i])        req[i] <= 1'b0;
            else if (!prev_q[i])     req[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_rank_pick.sv
// Rank picker: finds the highest-priority set bit of a vector. The order
// starts at the input just after `lowest` and wraps around. Reports the
// winning index and its rank (0 = best). Assumes N is a power of two.
module irq_rank_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] lowest,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] rank
);
    logic [IW-1:0] pos;

    // Scan from worst to best so the best match is assigned last.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        rank = '0;
        pos  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = lowest + IW'(1) + IW'(k);
            if (vec[pos]) begin
                any  = 1'b1;
                idx  = pos;
                rank = IW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Priority interrupt controller top. It holds the setup, mask, in-service
// and rotation state and runs the two-strobe acknowledge sequence. Requests
// come from irq_req_capture; arbitration uses two irq_rank_pick instances,
// one for pending requests and one for in-service bits. Assumes ack is a
// one-cycle strobe per pulse and N is a power of two with VEC_W > log2(N).
module irq_prio_ctrl #(
    parameter int N     = 8,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_in,
    input  logic             cs,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [VEC_W-1:0] wdata,
    input  logic             ack,
    output logic             int_out,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_oe
);
    import irq_pkg::*;

    localparam int IW     = $clog2(N);
    localparam int BASE_W = VEC_W - IW;

    logic [BASE_W-1:0] base_q;
    logic              rotate_q, auto_eoi_q, level_q;
    logic [N-1:0]      mask_q, isr_q, isr_nxt, req_q, req_clr;
    logic [IW-1:0]     lowest_q, idx_q;
    logic              phase_q, hit_q;

    logic          req_any, isr_any, fwd;
    logic [IW-1:0] req_idx, req_rank, isr_idx, isr_rank;
    logic          wr_hit, setup_wr, mask_wr, eoi_wr, first_ack, second_ack;

    // Decode configuration writes and acknowledge phase.
    always_comb begin
        wr_hit     = cs && wr_en;
        setup_wr   = wr_hit && (addr == ADDR_SETUP);
        mask_wr    = wr_hit && (addr == ADDR_MASK);
        eoi_wr     = wr_hit && (addr == ADDR_CMD) && wdata[BIT_EOI];
        first_ack  = ack && !phase_q;
        second_ack = ack && phase_q;
    end

    irq_req_capture #(.N(N)) u_cap (
        .clk(clk), .rst_n(rst_n), .irq(irq_in), .level_mode(level_q),
        .clr(req_clr), .req(req_q)
    );

    irq_rank_pick #(.N(N), .IW(IW)) u_pick_req (
        .vec(req_q & ~mask_q), .lowest(lowest_q),
        .any(req_any), .idx(req_idx), .rank(req_rank)
    );

    irq_rank_pick #(.N(N), .IW(IW)) u_pick_isr (
        .vec(isr_q), .lowest(lowest_q),
        .any(isr_any), .idx(isr_idx), .rank(isr_rank)
    );

    // Forward a request only if it outranks everything in service.
    always_comb begin
        fwd = req_any && (!isr_any || (req_rank < isr_rank));
    end

    // Next in-service value and request clear for this cycle.
    always_comb begin
        isr_nxt = isr_q;
        req_clr = '0;
        if (first_ack && fwd) begin
            isr_nxt[req_idx] = 1'b1;
            req_clr[req_idx] = 1'b1;
        end
        if (second_ack && auto_eoi_q && hit_q) isr_nxt[idx_q] = 1'b0;
        if (eoi_wr && isr_any)                 isr_nxt[isr_idx] = 1'b0;
        if (setup_wr)                          isr_nxt = '0;
    end

    // Setup and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            rotate_q   <= 1'b0;
            auto_eoi_q <= 1'b0;
            level_q    <= 1'b0;
            mask_q     <= '0;
        end else begin
            if (setup_wr) begin
                base_q     <= wdata[VEC_W-1 -: BASE_W];
                rotate_q   <= wdata[BIT_ROT];
                auto_eoi_q <= wdata[BIT_AUTO];
                level_q    <= wdata[BIT_LEVEL];
            end
            if (mask_wr) mask_q <= wdata[N-1:0];
        end
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_nxt;
    end

    // Acknowledge sequencer: latch the winner on the first strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            idx_q   <= IW'(N - 1);
            hit_q   <= 1'b0;
        end else if (first_ack) begin
            phase_q <= 1'b1;
            idx_q   <= fwd ? req_idx : IW'(N - 1);
            hit_q   <= fwd;
        end else if (second_ack) begin
            phase_q <= 1'b0;
        end
    end

    // Rotation pointer: the input whose service ends drops to the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         lowest_q <= IW'(N - 1);
        else if (setup_wr)                                  lowest_q <= IW'(N - 1);
        else if (rotate_q && eoi_wr && isr_any)             lowest_q <= isr_idx;
        else if (rotate_q && second_ack && auto_eoi_q && hit_q) lowest_q <= idx_q;
    end

    // Drive outputs.
    always_comb begin
        int_out = fwd;
        vec_oe  = second_ack;
        vec_out = second_ack ? {base_q, idx_q} : '0;
    end
endmodule

// File: rtl/irq_prio_ctrl_checker.sv
// Checker for irq_prio_ctrl: temporal properties over ports and internal
// state, attached to every instance through bind.
module irq_prio_ctrl_checker #(
    parameter int N     = 8,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             wr_en,
    input logic             ack,
    input logic             int_out,
    input logic             vec_oe,
    input logic [VEC_W-1:0] vec_out,
    input logic [N-1:0]     mask_q,
    input logic [N-1:0]     req_q,
    input logic [N-1:0]     isr_q,
    input logic             phase_q,
    input logic             hit_q,
    input logic             auto_eoi_q
);
    localparam int IW = $clog2(N);

    // R9: vector is driven only on the second strobe, never twice running.
    p_vec_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |=> !vec_oe);

    // R5: a raised interrupt always has an unmasked request behind it.
    p_int_backed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(req_q & ~mask_q));

    // R4: with every input masked there is no interrupt.
    p_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !int_out);

    // R8: a forwarded first strobe adds exactly one in-service bit.
    p_first_ack_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !phase_q && int_out && !(cs && wr_en)) |=>
        ($countones(isr_q) == $countones($past(isr_q)) + 1));

    // R10: automatic end-of-interrupt clears only the bit just vectored.
    p_auto_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && phase_q && hit_q && auto_eoi_q && !(cs && wr_en)) |=>
        (isr_q == ($past(isr_q) & ~(N'(1) << $past(vec_out[IW-1:0])))));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_checker #(.N(N), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .ack(ack),
    .int_out(int_out), .vec_oe(vec_oe), .vec_out(vec_out),
    .mask_q(mask_q), .req_q(req_q), .isr_q(isr_q), .phase_q(phase_q),
    .hit_q(hit_q), .auto_eoi_q(auto_eoi_q)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cs = 1'b0, wr_en = 1'b0, ack = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       int_out, vec_oe;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cs(cs), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .ack(ack), .int_out(int_out),
        .vec_out(vec_out), .vec_oe(vec_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        cs = sel; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic eoi();
        write_reg(2'd2, 8'h20, 1'b1);
    endtask

    // Two acknowledge strobes; returns vector and first-strobe enable.
    task automatic ack_pair(output logic [7:0] vec, output logic oe_first, output logic oe_second);
        @(negedge clk); ack = 1'b1; #1 oe_first = vec_oe;
        @(negedge clk); ack = 1'b0;
        @(negedge clk); ack = 1'b1; #1 vec = vec_out; oe_second = vec_oe;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
        chk("R1 vec_oe after reset", {7'd0, vec_oe}, 8'h00);
        set_irq(8'h01);
        chk("R1 default unmasked", {7'd0, int_out}, 8'h01);
        set_irq(8'h00);
        chk("R6 drop before ack withdraws", {7'd0, int_out}, 8'h00);
    endtask

    task automatic t_fixed();
        logic [7:0] v; logic o1, o2;
        write_reg(2'd0, 8'h40, 1'b1);
        write_reg(2'd1, 8'h00, 1'b1);
        set_irq(8'h28);
        chk("R5 pending raises int", {7'd0, int_out}, 8'h01);
        ack_pair(v, o1, o2);
        chk("R8 no drive on first strobe", {7'd0, o1}, 8'h00);
        chk("R9 vec_oe on second strobe", {7'd0, o2}, 8'h01);
        chk("R3 fixed winner input 3", v, 8'h43);
        chk("R5 lower request blocked", {7'd0, int_out}, 8'h00);
        eoi();
        chk("R11 eoi releases lower", {7'd0, int_out}, 8'h01);
        ack_pair(v, o1, o2);
        chk("R3 next winner input 5", v, 8'h45);
        eoi();
        chk("R6 held line no re-request", {7'd0, int_out}, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v; logic o1, o2;
        write_reg(2'd0, 8'h40, 1'b1);
        write_reg(2'd1, 8'h04, 1'b1);
        set_irq(8'h04);
        chk("R4 masked input ignored", {7'd0, int_out}, 8'h00);
        write_reg(2'd1, 8'h00, 1'b0);
        chk("R2 write without cs ignored", {7'd0, int_out}, 8'h00);
        write_reg(2'd1, 8'h00, 1'b1);
        chk("R4 unmask forwards held request", {7'd0, int_out}, 8'h01);
        @(negedge clk); cs = 1'b1;
        ack_pair(v, o1, o2);
        @(negedge clk); cs = 1'b0;
        chk("R13 ack with cs high", v, 8'h42);
        eoi();
        set_irq(8'h00);
    endtask

    task automatic t_nest();
        logic [7:0] v; logic o1, o2;
        write_reg(2'd0, 8'h40, 1'b1);
        set_irq(8'h40);
        ack_pair(v, o1, o2);
        chk("R9 vector input 6", v, 8'h46);
        set_irq(8'h42);
        chk("R5 higher nests over service", {7'd0, int_out}, 8'h01);
        ack_pair(v, o1, o2);
        chk("R9 nested vector input 1", v, 8'h41);
        eoi();
        chk("R11 eoi clears top bit only", {7'd0, int_out}, 8'h00);
        eoi();
        set_irq(8'h00);
    endtask

    task automatic t_auto();
        logic [7:0] v; logic o1, o2;
        write_reg(2'd0, 8'h42, 1'b1);
        set_irq(8'h01);
        ack_pair(v, o1, o2);
        chk("R10 auto vector input 0", v, 8'h40);
        set_irq(8'h81);
        chk("R10 service auto ended", {7'd0, int_out}, 8'h01);
        ack_pair(v, o1, o2);
        chk("R10 vector input 7", v, 8'h47);
        set_irq(8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v; logic o1, o2;
        write_reg(2'd0, 8'h41, 1'b1);
        set_irq(8'h10);
        chk("R7 level raises int", {7'd0, int_out}, 8'h01);
        ack_pair(v, o1, o2);
        chk("R7 level vector input 4", v, 8'h44);
        chk("R7 blocked while in service", {7'd0, int_out}, 8'h00);
        eoi();
        chk("R7 re-request after eoi", {7'd0, int_out}, 8'h01);
        set_irq(8'h00);
        chk("R7 low line no request", {7'd0, int_out}, 8'h00);
    endtask

    task automatic t_rotate();
        logic [7:0] v; logic o1, o2;
        write_reg(2'd0, 8'hA4, 1'b1);
        set_irq(8'h01);
        ack_pair(v, o1, o2);
        chk("R12 first vector input 0", v, 8'hA0);
        eoi();
        set_irq(8'h00);
        set_irq(8'h03);
        ack_pair(v, o1, o2);
        chk("R12 input 0 now lowest", v, 8'hA1);
        eoi();
        ack_pair(v, o1, o2);
        chk("R12 input 0 after rotation", v, 8'hA0);
        eoi();
        set_irq(8'h00);
    endtask

    initial begin : watchdog
        #(20ns * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_mask();
        t_nest();
        t_auto();
        t_level();
        t_rotate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule